// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel that runs a transfer described by a chain of descriptors in memory. Software writes the address of the first descriptor into a pointer register and then writes 1 to bit 0 of the enable register. The channel then loads a six-word descriptor over a shared memory port and copies the descriptor's byte count from its source to its destination, one beat at a time. It then follows the descriptor's link word to the next descriptor. The chain ends when the link word holds a fixed end marker.

Each side of the copy has its own settings in one half of the descriptor's config word: beat width, burst size, and whether the address increments or stays fixed as a peripheral port. When either side is a fixed port, the channel waits for a request input before each burst. Software can pause and resume the channel, or stop it. While the channel runs, software can read its live config, addresses, remaining count and parameter word. One event pulse marks the end of each descriptor, and a second marks the end of the whole chain.

Top module: `lld_dma_channel`

## Requirements
- R1: After reset the channel is idle. Enable readback bit 0 reads 0, the live registers at offsets 0x0C to 0x1C read 0, and neither event output is high.
- R2: Writing 1 to bit 0 of offset 0x00 while idle starts the channel. The channel reads six 32-bit words from the first-descriptor address held at offset 0x08: config, source, destination, byte length, parameter, link. Bit 0 at offset 0x00 reads 1 while the channel is busy. Offsets 0x0C and 0x1C read back the config and parameter words.
- R3: A link word other than 0xFFFFF800 makes the channel load the descriptor at that address. The marker 0xFFFFF800 ends the chain. After the chain ends, queue_done pulses high for one cycle and the channel returns to idle.
- R4: pkg_done pulses for one cycle after the last beat of every descriptor whose length is not zero.
- R5: The source half of the config word holds the I/O flag at bit 5, the burst code at bits 8:7 and the width code at bits 10:9. The destination half holds the same fields 16 bits higher. A width code of 0, 1 or 2 means 1, 2 or 4 bytes. Each beat uses the smaller of the two widths and is driven on mem_size as that code.
- R6: A side whose I/O flag is 0 advances its address by the beat size after each beat. A side whose I/O flag is 1 keeps its address fixed. Offsets 0x10 and 0x14 show the live source and destination addresses.
- R7: When fewer bytes remain than the beat width, the remaining bytes move as 1-byte beats.
- R8: Offset 0x18 shows the descriptor's length minus the bytes already written.
- R9: If either side has its I/O flag set, each burst waits for drq high. A burst is 8 beats for burst code 2 and 1 beat for any other code. The burst code comes from the source side if the source is an I/O side, and from the destination side otherwise.
- R10: Writing 1 to bit 1 of offset 0x04 pauses the channel after its current beat, with no change to addresses or count. Writing 0 resumes the transfer. Bit 1 at offset 0x04 reads back the pause setting.
- R11: Writing 0 to bit 0 of offset 0x00 while busy returns the channel to idle at the next beat or word boundary, without a queue_done pulse.
- R12: A descriptor with length zero moves no data and raises no pkg_done. The channel goes straight on to its link word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| drq | input | 1 | Peripheral request, sampled before each burst |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | AW | Write data, right-justified |
| mem_gnt | input | 1 | Access accepted in this cycle |
| mem_rdata | input | AW | Read data, right-justified, valid with mem_gnt |
| pkg_done | output | 1 | One-cycle pulse at the end of a descriptor |
| queue_done | output | 1 | One-cycle pulse at the end of the chain |

## Verification
The copy path runs with four patterns: both sides linear at the full width, mixed widths that force the narrower beat, a length that leaves a 1-byte tail, and each side in turn held fixed. The bench counts memory writes and compares them with the beat rule. It also compares each destination image with the source bytes. Together these show whether width, step and tail handling are right for each side. A two-link chain and a chain that starts with a zero-length descriptor show whether the link is followed and whether the event pulses are counted per descriptor or per chain. A single one-cycle request pulse must yield exactly one 8-beat burst, which checks the burst length against the request gating. Pause and stop are applied mid-transfer, and the remaining count is checked against the number of writes already seen.

// File: rtl/lld_pkg.sv
// Shared constants, types and helpers for the chained-descriptor DMA channel.
// Assumes 32-bit descriptor words and byte addressing.
package lld_pkg;
    localparam logic [31:0] CHAIN_END = 32'hFFFF_F800;
    localparam int DESC_WORDS = 6;

    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_PAUSE  = 'h04;
    localparam int OFS_FIRST  = 'h08;
    localparam int OFS_CFG    = 'h0C;
    localparam int OFS_SRC    = 'h10;
    localparam int OFS_DST    = 'h14;
    localparam int OFS_CNT    = 'h18;
    localparam int OFS_PARA   = 'h1C;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_EVAL, ST_ARM, ST_READ, ST_WRITE, ST_STEP
    } eng_state_t;

    // Byte count of a width code; code 3 is treated as 4 bytes.
    function automatic logic [2:0] code_bytes(input logic [1:0] code);
        case (code)
            2'd0:    code_bytes = 3'd1;
            2'd1:    code_bytes = 3'd2;
            default: code_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/lld_regs.sv
// Register file: enable/stop command, pause flag, first-descriptor pointer and
// a combinational readback mux of the live engine state.
// Assumes one register access per cycle; start/stop leave as one-cycle pulses.
module lld_regs import lld_pkg::*; #(
    parameter int REG_AW = 5,
    parameter int AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    input  logic              busy,
    input  logic [AW-1:0]     live_cfg,
    input  logic [AW-1:0]     live_src,
    input  logic [AW-1:0]     live_dst,
    input  logic [AW-1:0]     live_cnt,
    input  logic [AW-1:0]     live_para,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              pause_q,
    output logic [AW-1:0]     first_ptr,
    output logic [AW-1:0]     reg_rdata
);
    logic wr_en, wr_pause, wr_first;
    assign wr_en    = reg_we && (reg_addr == REG_AW'(OFS_ENABLE));
    assign wr_pause = reg_we && (reg_addr == REG_AW'(OFS_PAUSE));
    assign wr_first = reg_we && (reg_addr == REG_AW'(OFS_FIRST));

    // Capture software writes and turn enable writes into command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            pause_q     <= 1'b0;
            first_ptr   <= '0;
        end else begin
            start_pulse <= wr_en && reg_wdata[0];
            stop_pulse  <= wr_en && !reg_wdata[0];
            if (wr_pause) pause_q <= reg_wdata[1];
            if (wr_first) first_ptr <= reg_wdata;
        end
    end

    // Readback of control and live registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(OFS_ENABLE): reg_rdata[0] = busy;
            REG_AW'(OFS_PAUSE):  reg_rdata[1] = pause_q;
            REG_AW'(OFS_FIRST):  reg_rdata = first_ptr;
            REG_AW'(OFS_CFG):    reg_rdata = live_cfg;
            REG_AW'(OFS_SRC):    reg_rdata = live_src;
            REG_AW'(OFS_DST):    reg_rdata = live_dst;
            REG_AW'(OFS_CNT):    reg_rdata = live_cnt;
            REG_AW'(OFS_PARA):   reg_rdata = live_para;
            default:             reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lld_beat_calc.sv
// Combinational beat planner: picks the beat size from the two side widths
// and the remaining count, the burst length, and whether drq gates bursts.
// Assumes width/burst codes arrive straight from the config word halves.
module lld_beat_calc import lld_pkg::*; #(
    parameter int AW = 32
) (
    input  logic [1:0]    src_w,
    input  logic [1:0]    dst_w,
    input  logic [1:0]    src_b,
    input  logic [1:0]    dst_b,
    input  logic          src_io,
    input  logic          dst_io,
    input  logic [AW-1:0] remaining,
    output logic [1:0]    beat_code,
    output logic [2:0]    beat_bytes,
    output logic [3:0]    burst_len,
    output logic          need_drq
);
    logic [1:0] narrow;
    logic [1:0] burst_sel;

    // Narrower side sets the beat; short tails fall back to single bytes.
    always_comb begin
        narrow = (src_w < dst_w) ? src_w : dst_w;
        if (narrow == 2'd3) narrow = 2'd2;
        beat_code = narrow;
        if (remaining < AW'(code_bytes(narrow))) beat_code = 2'd0;
    end

    assign beat_bytes = code_bytes(beat_code);
    assign burst_sel  = src_io ? src_b : dst_b;
    assign burst_len  = (burst_sel == 2'd2) ? 4'd8 : 4'd1;
    assign need_drq   = src_io || dst_io;
endmodule

// File: rtl/lld_engine.sv
// Channel sequencer: fetches six-word descriptors, runs read/write beats in
// drq-gated bursts, follows link words and raises the completion pulses.
// Assumes mem_gnt may arrive in the cycle of the request; data right-justified.
module lld_engine import lld_pkg::*; #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_pulse,
    input  logic          stop_pulse,
    input  logic          pause_q,
    input  logic [AW-1:0] first_ptr,
    input  logic          drq,
    input  logic [1:0]    beat_code,
    input  logic [2:0]    beat_bytes,
    input  logic [3:0]    burst_len,
    input  logic          need_drq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic [AW-1:0] live_cfg,
    output logic [AW-1:0] live_src,
    output logic [AW-1:0] live_dst,
    output logic [AW-1:0] live_cnt,
    output logic [AW-1:0] live_para,
    output logic          pkg_done,
    output logic          queue_done,
    output eng_state_t    state
);
    localparam int WIDX_W = $clog2(DESC_WORDS);
    localparam int SRC_IO_BIT = 5;
    localparam int DST_IO_BIT = SRC_IO_BIT + 16;

    logic [AW-1:0]     desc_ptr, next_ptr, data_q;
    logic [WIDX_W-1:0] widx;
    logic [3:0]        beats_left;
    logic              stop_pend;
    logic [AW-1:0]     step;

    assign busy = (state != ST_IDLE);
    assign step = AW'(beat_bytes);

    // Drive the memory port from the current phase.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = data_q;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'({widx, 2'b00});
            end
            ST_READ: begin
                mem_req  = !pause_q && !stop_pend;
                mem_addr = live_src;
                mem_size = beat_code;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = live_dst;
                mem_size = beat_code;
            end
            default: ;
        endcase
    end

    // Phase sequencing, descriptor capture and live address/count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            desc_ptr   <= '0;
            next_ptr   <= '0;
            data_q     <= '0;
            widx       <= '0;
            beats_left <= '0;
            stop_pend  <= 1'b0;
            live_cfg   <= '0;
            live_src   <= '0;
            live_dst   <= '0;
            live_cnt   <= '0;
            live_para  <= '0;
            pkg_done   <= 1'b0;
            queue_done <= 1'b0;
        end else begin
            pkg_done   <= 1'b0;
            queue_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start_pulse) begin
                        desc_ptr <= first_ptr;
                        widx     <= '0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_gnt) begin
                    case (widx)
                        WIDX_W'(0): live_cfg  <= mem_rdata;
                        WIDX_W'(1): live_src  <= mem_rdata;
                        WIDX_W'(2): live_dst  <= mem_rdata;
                        WIDX_W'(3): live_cnt  <= mem_rdata;
                        WIDX_W'(4): live_para <= mem_rdata;
                        default:    next_ptr  <= mem_rdata;
                    endcase
                    if (stop_pend)                             state <= ST_IDLE;
                    else if (widx == WIDX_W'(DESC_WORDS - 1))  state <= ST_EVAL;
                    else                                       widx  <= widx + 1'b1;
                end
                ST_EVAL: begin
                    if (stop_pend)             state <= ST_IDLE;
                    else if (live_cnt == '0)   state <= ST_STEP;
                    else                       state <= ST_ARM;
                end
                ST_ARM: begin
                    if (stop_pend) state <= ST_IDLE;
                    else if (!need_drq || drq) begin
                        beats_left <= burst_len;
                        state      <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (stop_pend) state <= ST_IDLE;
                    else if (mem_gnt) begin
                        data_q <= mem_rdata;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: if (mem_gnt) begin
                    if (!live_cfg[SRC_IO_BIT]) live_src <= live_src + step;
                    if (!live_cfg[DST_IO_BIT]) live_dst <= live_dst + step;
                    live_cnt   <= live_cnt - step;
                    beats_left <= beats_left - 1'b1;
                    if (live_cnt == step) begin
                        pkg_done <= 1'b1;
                        state    <= ST_STEP;
                    end else if (beats_left == 4'd1) state <= ST_ARM;
                    else                             state <= ST_READ;
                end
                ST_STEP: begin
                    if (next_ptr == CHAIN_END) begin
                        queue_done <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (stop_pend) state <= ST_IDLE;
                    else begin
                        desc_ptr <= next_ptr;
                        widx     <= '0;
                        state    <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (stop_pulse && state != ST_IDLE) stop_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/lld_dma_channel.sv
// Top of the chained-descriptor DMA channel: register file, beat planner and
// sequencer. Assumes a single shared memory port and a level drq input.
module lld_dma_channel import lld_pkg::*; #(
    parameter int REG_AW = 5,
    parameter int AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              drq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [AW-1:0]     mem_wdata,
    input  logic              mem_gnt,
    input  logic [AW-1:0]     mem_rdata,
    output logic              pkg_done,
    output logic              queue_done
);
    localparam int HALF = 16;

    logic          start_pulse, stop_pulse, pause_q, busy, need_drq;
    logic [AW-1:0] first_ptr, live_cfg, live_src, live_dst, live_cnt, live_para;
    logic [1:0]    beat_code;
    logic [2:0]    beat_bytes;
    logic [3:0]    burst_len;
    eng_state_t    eng_state;

    lld_regs #(.REG_AW(REG_AW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .live_cfg(live_cfg),
        .live_src(live_src), .live_dst(live_dst), .live_cnt(live_cnt),
        .live_para(live_para), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .pause_q(pause_q), .first_ptr(first_ptr),
        .reg_rdata(reg_rdata)
    );

    lld_beat_calc #(.AW(AW)) u_beat (
        .src_w(live_cfg[10:9]), .dst_w(live_cfg[HALF+10:HALF+9]),
        .src_b(live_cfg[8:7]),  .dst_b(live_cfg[HALF+8:HALF+7]),
        .src_io(live_cfg[5]),   .dst_io(live_cfg[HALF+5]),
        .remaining(live_cnt), .beat_code(beat_code), .beat_bytes(beat_bytes),
        .burst_len(burst_len), .need_drq(need_drq)
    );

    lld_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .pause_q(pause_q), .first_ptr(first_ptr),
        .drq(drq), .beat_code(beat_code), .beat_bytes(beat_bytes),
        .burst_len(burst_len), .need_drq(need_drq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .live_cfg(live_cfg), .live_src(live_src),
        .live_dst(live_dst), .live_cnt(live_cnt), .live_para(live_para),
        .pkg_done(pkg_done), .queue_done(queue_done), .state(eng_state)
    );
endmodule

// File: rtl/lld_dma_channel_chk.sv
// Property checker for the DMA channel, attached to the top by bind.
module lld_dma_channel_chk import lld_pkg::*; #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [1:0]    mem_size,
    input logic          pkg_done,
    input logic          queue_done,
    input logic          pause_q,
    input logic [AW-1:0] live_cnt,
    input eng_state_t    eng_state
);
    // R4: a descriptor-end pulse lasts one cycle.
    p_pkg_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_done |=> !pkg_done);

    // R3: the chain-end pulse coincides with the return to idle.
    p_queue_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        queue_done |-> eng_state == ST_IDLE);

    // R11: an idle (or stopped) channel issues no memory traffic.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_state == ST_IDLE |-> !mem_req);

    // R10: once the pause has been seen for a full cycle, no beat traffic.
    p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_q && $past(pause_q) && eng_state != ST_FETCH) |-> !mem_req);

    // R8: every accepted data write lowers the remaining count.
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |=> live_cnt < $past(live_cnt));

    // R5: only the 1/2/4-byte size codes reach the memory port.
    p_size_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'd3);

    // R2: descriptor loads are full-word reads.
    p_fetch_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_state == ST_FETCH |-> (mem_size == 2'd2 && !mem_we));
endmodule

bind lld_dma_channel lld_dma_channel_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_gnt(mem_gnt), .mem_size(mem_size), .pkg_done(pkg_done),
    .queue_done(queue_done), .pause_q(pause_q), .live_cnt(live_cnt),
    .eng_state(eng_state)
);

// File: tb/test_lld_dma_channel.sv
// Directed bench: one task per scenario, byte-array memory model.
module test_lld_dma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drq = 1'b1;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        pkg_done, queue_done;

    logic [7:0] mem [0:1023];
    int n_chk = 0, n_bad = 0, cyc = 0;
    int wr_cnt = 0, pkg_cnt = 0, q_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lld_dma_channel i_lld_dma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .pkg_done(pkg_done), .queue_done(queue_done)
    );

    // Always-ready memory with right-justified little-endian data.
    assign mem_gnt = mem_req;
    always_comb begin
        logic [9:0] a;
        a = mem_addr[9:0];
        mem_rdata = {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && mem_req && mem_we) begin
            for (int i = 0; i < 4; i++)
                if (i < (1 << mem_size)) mem[mem_addr[9:0] + 10'(i)] <= mem_wdata[8*i +: 8];
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n && pkg_done)   pkg_cnt <= pkg_cnt + 1;
        if (rst_n && queue_done) q_cnt <= q_cnt + 1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 100000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) mem[10'(a + i)] = w[8*i +: 8];
    endtask

    function automatic logic [31:0] mk_cfg(input bit sio, input int sb, input int sw,
                                           input bit dio, input int db, input int dw);
        logic [15:0] s, d;
        s = 16'((sw << 9) | (sb << 7) | (int'(sio) << 5) | 1);
        d = 16'((dw << 9) | (db << 7) | (int'(dio) << 5) | 1);
        return {d, s};
    endfunction

    task automatic put_desc(input int at, input logic [31:0] cfg, input int src,
                            input int dst, input int len, input logic [31:0] nxt);
        put_word(at, cfg); put_word(at + 4, src); put_word(at + 8, dst);
        put_word(at + 12, len); put_word(at + 16, 32'h8); put_word(at + 20, nxt);
    endtask

    task automatic start_at(input int first);
        reg_write(5'h08, first);
        reg_write(5'h00, 32'h1);
    endtask

    task automatic wait_queue(input int q0, input string tag);
        int n = 0;
        while (q_cnt == q0 && n < 2000) begin @(negedge clk); n++; end
        check(q_cnt != q0, tag, q_cnt - q0, 1);
    endtask

    task automatic chk_copy(input int src, input int dst, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[10'(dst + i)] !== mem[10'(src + i)]) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(5'h00, v); check(v == 0, "R1 enable readback", v, 0);
        for (int a = 'h0C; a <= 'h1C; a += 4) begin
            reg_read(5'(a), v); check(v == 0, "R1 live register", v, 0);
        end
        check(!pkg_done && !queue_done && pkg_cnt == 0 && q_cnt == 0, "R1 events idle",
              pkg_cnt + q_cnt, 0);
    endtask

    task automatic t_single();
        int w0 = wr_cnt, p0 = pkg_cnt, q0 = q_cnt;
        logic [31:0] v, cfg;
        cfg = mk_cfg(0, 2, 2, 0, 2, 2);
        put_desc('h100, cfg, 'h200, 'h300, 16, 32'hFFFF_F800);
        start_at('h100);
        reg_read(5'h00, v); check(v[0], "R2 busy while running", v, 1);
        wait_queue(q0, "R3 queue_done single");
        chk_copy('h200, 'h300, 16, "R6 linear copy");
        check(wr_cnt - w0 == 4, "R5 four-byte beats", wr_cnt - w0, 4);
        check(pkg_cnt - p0 == 1, "R4 one pkg_done", pkg_cnt - p0, 1);
        reg_read(5'h0C, v); check(v == cfg, "R2 config word loaded", v, cfg);
        reg_read(5'h1C, v); check(v == 8, "R2 parameter word loaded", v, 8);
        reg_read(5'h10, v); check(v == 'h210, "R6 source advanced", v, 'h210);
        reg_read(5'h18, v); check(v == 0, "R8 count drained", v, 0);
        reg_read(5'h00, v); check(v[0] == 0, "R3 idle after chain", v, 0);
    endtask

    task automatic t_chain();
        int w0 = wr_cnt, p0 = pkg_cnt, q0 = q_cnt;
        logic [31:0] v;
        put_desc('h100, mk_cfg(0, 0, 0, 0, 0, 0), 'h220, 'h320, 5, 'h120);
        put_desc('h120, mk_cfg(0, 0, 1, 0, 0, 1), 'h230, 'h330, 6, 32'hFFFF_F800);
        start_at('h100);
        wait_queue(q0, "R3 queue_done chain");
        chk_copy('h220, 'h320, 5, "R3 first link data");
        chk_copy('h230, 'h330, 6, "R3 second link data");
        check(pkg_cnt - p0 == 2, "R4 pkg_done per link", pkg_cnt - p0, 2);
        check(q_cnt - q0 == 1, "R3 single queue_done", q_cnt - q0, 1);
        check(wr_cnt - w0 == 8, "R5 1B and 2B beats", wr_cnt - w0, 8);
        reg_read(5'h10, v); check(v == 'h236, "R6 live source of last link", v, 'h236);
    endtask

    task automatic t_width_tail();
        int w0 = wr_cnt, q0 = q_cnt;
        put_desc('h100, mk_cfg(0, 0, 2, 0, 0, 2), 'h240, 'h340, 6, 'h120);
        put_desc('h120, mk_cfg(0, 0, 2, 0, 0, 0), 'h250, 'h350, 4, 32'hFFFF_F800);
        start_at('h100);
        wait_queue(q0, "R7 queue_done");
        chk_copy('h240, 'h340, 6, "R7 tail data");
        chk_copy('h250, 'h350, 4, "R5 narrow-side data");
        check(wr_cnt - w0 == 7, "R7 tail plus narrow beats", wr_cnt - w0, 7);
    endtask

    task automatic t_fixed();
        int q0 = q_cnt;
        logic [31:0] v;
        put_desc('h100, mk_cfg(1, 0, 0, 0, 0, 0), 'h260, 'h360, 4, 32'hFFFF_F800);
        start_at('h100);
        wait_queue(q0, "R6 queue_done fixed source");
        for (int i = 0; i < 4; i++)
            check(mem[10'('h360 + i)] == mem[10'h260], "R6 fixed source repeats",
                  mem[10'('h360 + i)], mem[10'h260]);
        reg_read(5'h10, v); check(v == 'h260, "R6 source held", v, 'h260);
        q0 = q_cnt;
        put_desc('h100, mk_cfg(0, 0, 0, 1, 0, 0), 'h270, 'h370, 4, 32'hFFFF_F800);
        start_at('h100);
        wait_queue(q0, "R6 queue_done fixed dest");
        check(mem[10'h370] == mem[10'h273], "R6 fixed dest holds last", mem[10'h370], mem[10'h273]);
        check(mem[10'h371] == 0, "R6 fixed dest no spill", mem[10'h371], 0);
        reg_read(5'h14, v); check(v == 'h370, "R6 dest held", v, 'h370);
    endtask

    task automatic t_zero_len();
        int p0 = pkg_cnt, q0 = q_cnt;
        put_desc('h100, mk_cfg(0, 0, 0, 0, 0, 0), 'h200, 'h3F0, 0, 'h120);
        put_desc('h120, mk_cfg(0, 0, 0, 0, 0, 0), 'h280, 'h380, 4, 32'hFFFF_F800);
        start_at('h100);
        wait_queue(q0, "R12 queue_done");
        check(pkg_cnt - p0 == 1, "R12 no pkg_done for empty link", pkg_cnt - p0, 1);
        check(mem[10'h3F0] == 0, "R12 empty link moved nothing", mem[10'h3F0], 0);
        chk_copy('h280, 'h380, 4, "R12 following link data");
    endtask

    task automatic t_drq();
        int w0 = wr_cnt, q0 = q_cnt;
        drq = 1'b0;
        put_desc('h100, mk_cfg(1, 2, 0, 0, 0, 0), 'h290, 'h390, 16, 32'hFFFF_F800);
        start_at('h100);
        repeat (30) @(negedge clk);
        check(wr_cnt == w0, "R9 no beats without drq", wr_cnt - w0, 0);
        drq = 1'b1; @(negedge clk); drq = 1'b0;
        repeat (40) @(negedge clk);
        check(wr_cnt - w0 == 8, "R9 one request gives 8 beats", wr_cnt - w0, 8);
        drq = 1'b1;
        wait_queue(q0, "R9 queue_done");
        check(wr_cnt - w0 == 16, "R9 all beats done", wr_cnt - w0, 16);
    endtask

    task automatic t_pause();
        int w0 = wr_cnt, q0 = q_cnt, n = 0, d1, d2;
        logic [31:0] c1, c2, v;
        put_desc('h100, mk_cfg(0, 0, 0, 0, 0, 0), 'h200, 'h3C0, 64, 32'hFFFF_F800);
        start_at('h100);
        while (wr_cnt - w0 < 5 && n < 500) begin @(negedge clk); n++; end
        reg_write(5'h04, 32'h2);
        repeat (5) @(negedge clk);
        d1 = wr_cnt - w0; reg_read(5'h18, c1);
        repeat (20) @(negedge clk);
        d2 = wr_cnt - w0; reg_read(5'h18, c2);
        check(d1 == d2, "R10 no beats while paused", d2, d1);
        check(c1 == c2, "R10 count held while paused", c2, c1);
        check(c1 == 64 - d1, "R8 count equals bytes left", c1, 64 - d1);
        reg_read(5'h04, v); check(v == 2, "R10 pause readback", v, 2);
        reg_read(5'h00, v); check(v[0], "R10 still busy when paused", v, 1);
        reg_write(5'h04, 32'h0);
        wait_queue(q0, "R10 resume completes");
        chk_copy('h200, 'h3C0, 64, "R10 data after resume");
    endtask

    task automatic t_stop();
        int w0 = wr_cnt, q0 = q_cnt, n = 0;
        logic [31:0] v;
        put_desc('h100, mk_cfg(0, 0, 0, 0, 0, 0), 'h200, 'h3C0, 64, 32'hFFFF_F800);
        start_at('h100);
        while (wr_cnt - w0 < 3 && n < 500) begin @(negedge clk); n++; end
        reg_write(5'h00, 32'h0);
        repeat (10) @(negedge clk);
        reg_read(5'h00, v); check(v[0] == 0, "R11 idle after stop", v, 0);
        check(q_cnt == q0, "R11 no queue_done on stop", q_cnt - q0, 0);
        check(wr_cnt - w0 < 64, "R11 transfer cut short", wr_cnt - w0, 10);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i >= 'h200 && i < 'h300) ? 8'(i * 7 + 3) : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_chain();
        t_width_tail();
        t_fixed();
        t_zero_len();
        t_drq();
        t_pause();
        t_stop();
        done = 1;
        summary();
    end
endmodule